// File: doc/BRIEF.md
# Privileged Timestamp Counter

This block keeps a 64-bit cycle counter that advances by one on every clock after reset and that software can load with any value. It sits inside a register access unit: a generic read or write names a register by a 32-bit index, and the counter answers to index 0x10. Data crosses the port as two 32-bit words. The high word holds bits 63:32 and the low word holds bits 31:0.

A second path, the fast timestamp read, returns the same value without an index. Its permission depends on a disable control bit. When the bit is clear, any privilege level may use it. When the bit is set, only level 0 may use it. Generic reads and writes always require level 0. Each request receives one response in the following cycle. A denied request receives a fault pulse and zero data, and it leaves the counter unchanged.

Top module: `tsc_unit`

## Requirements
- R1: While `rst_n` is low, the counter is held at zero and `rsp_valid`, `rsp_fault` and both data words are zero.
- R2: After reset, the counter rises by exactly one per clock. A read returns the value the counter held at the request edge, which is the value before that edge's increment. The response appears in the next cycle.
- R3: The counter wraps from all ones to zero and raises no fault.
- R4: A generic write with index 0x10 at privilege 0 loads {`req_wdata_hi`,`req_wdata_lo`}. It replaces that cycle's increment, so a read in the next cycle returns the loaded value, and counting continues from there.
- R5: A permitted generic read returns bits 63:32 on `rsp_rdata_hi` and bits 31:0 on `rsp_rdata_lo`.
- R6: A generic read or write at a privilege level other than 0 faults and returns zero data. A write denied this way does not change the counter.
- R7: A generic read or write with an index other than 0x10 faults and returns zero data. A write denied this way does not change the counter.
- R8: A fast timestamp read with `req_tsd` = 0 succeeds at every privilege level and returns the count.
- R9: A fast timestamp read with `req_tsd` = 1 succeeds only at privilege 0. At any other level it faults and returns zero data.
- R10: Every cycle with any strobe is followed by exactly one cycle with `rsp_valid` high. `rsp_fault` is high only together with `rsp_valid`. A cycle with no strobe is followed by `rsp_valid` and `rsp_fault` both low.
- R11: When several strobes are high in one cycle, only one request is served: write first, then generic read, then fast read. The response to a write carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Generic register read strobe |
| req_wr | input | 1 | Generic register write strobe |
| req_idx | input | 32 | Register index for generic access |
| req_wdata_hi | input | 32 | Write data, bits 63:32 |
| req_wdata_lo | input | 32 | Write data, bits 31:0 |
| req_cpl | input | 2 | Current privilege level (0 is most privileged) |
| req_tsd | input | 1 | Fast-read disable control: 1 limits the fast read to level 0 |
| req_rdts | input | 1 | Fast timestamp read strobe |
| rsp_valid | output | 1 | Response present (one cycle after a request) |
| rsp_rdata_hi | output | 32 | Read data, bits 63:32 |
| rsp_rdata_lo | output | 32 | Read data, bits 31:0 |
| rsp_fault | output | 1 | Request denied, single-cycle pulse |

## Verification
The bench targets the following corner cases:

- **Write followed by a read in the next cycle.** A design that still adds one on the load edge returns the written value plus one.
- **Counter wrap.** The bench loads all ones and then reads twice. A design with a carry or width error, or one that treats the wrap as an error, shows a nonzero second value or a fault.
- **Denied writes.** The bench writes with a wrong index and with a nonzero privilege level, then reads. A design that loads anyway returns the rejected value instead of the running count.
- **Permission matrix and strobe collisions.** The bench covers all combinations of the disable bit and privilege level for the fast read, and it raises several strobes in one cycle. A design with inverted gating or the wrong priority shows a stray fault or nonzero write-response data.

// File: rtl/tsc_pkg.sv
// Package tsc_pkg: shared types for the timestamp counter unit.
// Assumes: one request kind is served per cycle, chosen by fixed priority.
package tsc_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2,
        OP_RDTS = 2'd3
    } tsc_op_e;
endpackage

// File: rtl/tsc_access_ctl.sv
// Module tsc_access_ctl: picks the request to serve and decides whether it is
// permitted.
// Priority is write, then generic read, then fast read. Generic access needs
// index TSC_IDX and privilege 0. The fast read needs privilege 0 only while the
// disable bit is set.
// Assumes: purely combinational; the response stage registers its outputs.
module tsc_access_ctl
    import tsc_pkg::*;
#(
    parameter int IDX_W   = 32,
    parameter int PRIV_W  = 2,
    parameter logic [IDX_W-1:0] TSC_IDX = 'h10
) (
    input  logic              rd,
    input  logic              wr,
    input  logic              rdts,
    input  logic [IDX_W-1:0]  idx,
    input  logic [PRIV_W-1:0] cpl,
    input  logic              tsd,
    output tsc_op_e           op,
    output logic              fault,
    output logic              load_en
);
    logic idx_hit;
    logic top_priv;

    assign idx_hit  = (idx == TSC_IDX);
    assign top_priv = (cpl == '0);

    // Select one request by fixed priority.
    always_comb begin
        if (wr)        op = OP_WR;
        else if (rd)   op = OP_RD;
        else if (rdts) op = OP_RDTS;
        else           op = OP_NONE;
    end

    // Permission check for the selected request.
    always_comb begin
        unique case (op)
            OP_WR, OP_RD: fault = !(idx_hit && top_priv);
            OP_RDTS:      fault = tsd && !top_priv;
            default:      fault = 1'b0;
        endcase
    end

    assign load_en = (op == OP_WR) && !fault;
endmodule

// File: rtl/tsc_counter.sv
// Module tsc_counter: free-running cycle counter with a synchronous load.
// A load replaces that cycle's increment. The count wraps silently at all ones.
// Assumes: synchronous active-low reset to zero.
module tsc_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q
);
    // Count state: clear, load, or advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load_en) cnt_q <= load_val;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/tsc_resp.sv
// Module tsc_resp: registers the one-cycle response.
// The counter value captured at the request edge is split into NWORDS data
// words. Denied requests and writes return zero data.
// Assumes: CNT_W is a multiple of WORD_W.
module tsc_resp
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32,
    localparam int NWORDS = CNT_W / WORD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  tsc_op_e                      op,
    input  logic                         fault,
    input  logic [CNT_W-1:0]             cnt,
    output logic                         valid,
    output logic                         fault_q,
    output logic [NWORDS-1:0][WORD_W-1:0] words
);
    logic             ret_data;
    logic [CNT_W-1:0] data_q;

    assign ret_data = ((op == OP_RD) || (op == OP_RDTS)) && !fault;

    // Response registers: valid, fault pulse and returned count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            fault_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid   <= (op != OP_NONE);
            fault_q <= fault;
            data_q  <= ret_data ? cnt : '0;
        end
    end

    // Split the captured count into words, least significant first.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign words[w] = data_q[w*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/tsc_unit.sv
// Module tsc_unit: top of the privileged timestamp counter.
// Joins the access control, the counter and the response stage.
// Assumes: a single clock domain and a synchronous active-low reset.
module tsc_unit
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int IDX_W  = 32,
    parameter int PRIV_W = 2,
    parameter logic [IDX_W-1:0] TSC_IDX = 'h10,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [HALF_W-1:0] req_wdata_hi,
    input  logic [HALF_W-1:0] req_wdata_lo,
    input  logic [PRIV_W-1:0] req_cpl,
    input  logic              req_tsd,
    input  logic              req_rdts,
    output logic              rsp_valid,
    output logic [HALF_W-1:0] rsp_rdata_hi,
    output logic [HALF_W-1:0] rsp_rdata_lo,
    output logic              rsp_fault
);
    tsc_op_e                  op;
    logic                     fault;
    logic                     load_en;
    logic [CNT_W-1:0]         cnt_q;
    logic [1:0][HALF_W-1:0]   words;

    tsc_access_ctl #(
        .IDX_W(IDX_W), .PRIV_W(PRIV_W), .TSC_IDX(TSC_IDX)
    ) u_ctl (
        .rd(req_rd), .wr(req_wr), .rdts(req_rdts), .idx(req_idx),
        .cpl(req_cpl), .tsd(req_tsd),
        .op(op), .fault(fault), .load_en(load_en)
    );

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .load_val({req_wdata_hi, req_wdata_lo}), .cnt_q(cnt_q)
    );

    tsc_resp #(.CNT_W(CNT_W), .WORD_W(HALF_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .op(op), .fault(fault), .cnt(cnt_q),
        .valid(rsp_valid), .fault_q(rsp_fault), .words(words)
    );

    assign rsp_rdata_lo = words[0];
    assign rsp_rdata_hi = words[1];
endmodule

// File: rtl/tsc_unit_chk.sv
// Module tsc_unit_chk: protocol and counting properties for tsc_unit.
// Bound to every tsc_unit instance.
module tsc_unit_chk #(
    parameter int CNT_W  = 64,
    parameter int IDX_W  = 32,
    parameter int PRIV_W = 2,
    parameter logic [IDX_W-1:0] TSC_IDX = 'h10,
    localparam int HALF_W = CNT_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_rd,
    input logic              req_wr,
    input logic              req_rdts,
    input logic [IDX_W-1:0]  req_idx,
    input logic [HALF_W-1:0] req_wdata_hi,
    input logic [HALF_W-1:0] req_wdata_lo,
    input logic [PRIV_W-1:0] req_cpl,
    input logic              req_tsd,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [HALF_W-1:0] rsp_rdata_hi,
    input logic [HALF_W-1:0] rsp_rdata_lo,
    input logic [CNT_W-1:0]  cnt,
    input logic              load_en
);
    logic any_req;
    assign any_req = req_rd || req_wr || req_rdts;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_fault && rsp_rdata_hi == '0 && rsp_rdata_lo == '0));

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> cnt == $past(cnt) + CNT_W'(1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && cnt == '1) |=> cnt == '0);

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cnt == $past({req_wdata_hi, req_wdata_lo}));

    p_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_rd || req_wr) && req_cpl != '0) |=> rsp_fault);

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_rdata_hi == '0 && rsp_rdata_lo == '0));

    p_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_rd || req_wr) && req_idx != TSC_IDX) |=> rsp_fault);

    p_rdts_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rdts && !req_rd && !req_wr && !req_tsd) |=> (rsp_valid && !rsp_fault));

    p_rdts_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rdts && !req_rd && !req_wr && req_tsd && req_cpl != '0) |=> rsp_fault);

    p_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> rsp_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (!rsp_valid && !rsp_fault));

    p_fault_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    p_wr_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> (rsp_rdata_hi == '0 && rsp_rdata_lo == '0));
endmodule

bind tsc_unit tsc_unit_chk #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .PRIV_W(PRIV_W), .TSC_IDX(TSC_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_rdts(req_rdts), .req_idx(req_idx), .req_wdata_hi(req_wdata_hi),
    .req_wdata_lo(req_wdata_lo), .req_cpl(req_cpl), .req_tsd(req_tsd),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rdata_hi(rsp_rdata_hi), .rsp_rdata_lo(rsp_rdata_lo),
    .cnt(cnt_q), .load_en(load_en)
);

// File: tb/tsc_unit_tb.sv
`timescale 1ns/1ps
// Bench tsc_unit_tb: a vector table for the permission matrix, then directed
// tests for reset, increment, wrap and pulse width.
module tsc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0, req_wr = 1'b0, req_rdts = 1'b0, req_tsd = 1'b0;
    logic [31:0] req_idx = '0, req_wdata_hi = '0, req_wdata_lo = '0;
    logic [1:0]  req_cpl = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_rdata_hi, rsp_rdata_lo;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [63:0] model = '0;   // expected count as seen at the next request edge

    always #2.5 clk = ~clk;    // 200 MHz

    tsc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_idx(req_idx), .req_wdata_hi(req_wdata_hi), .req_wdata_lo(req_wdata_lo),
        .req_cpl(req_cpl), .req_tsd(req_tsd), .req_rdts(req_rdts),
        .rsp_valid(rsp_valid), .rsp_rdata_hi(rsp_rdata_hi),
        .rsp_rdata_lo(rsp_rdata_lo), .rsp_fault(rsp_fault)
    );

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        rdts;
        logic [31:0] idx;
        logic [1:0]  cpl;
        logic        tsd;
        logic [63:0] wval;
        logic        exp_fault;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 32'h10, 2'd0, 1'b0, 64'h0, 1'b0, 4'd5},    // R5 read ok
        '{1'b1, 1'b0, 1'b0, 32'h10, 2'd3, 1'b0, 64'h0, 1'b1, 4'd6},    // R6 read bad cpl
        '{1'b0, 1'b1, 1'b0, 32'h10, 2'd1, 1'b0, 64'hDEAD, 1'b1, 4'd6}, // R6 write bad cpl
        '{1'b1, 1'b0, 1'b0, 32'h10, 2'd0, 1'b0, 64'h0, 1'b0, 4'd6},    // R6 count unchanged
        '{1'b0, 1'b1, 1'b0, 32'h11, 2'd0, 1'b0, 64'hBEEF, 1'b1, 4'd7}, // R7 write bad idx
        '{1'b1, 1'b0, 1'b0, 32'h0,  2'd0, 1'b0, 64'h0, 1'b1, 4'd7},    // R7 read bad idx
        '{1'b0, 1'b0, 1'b1, 32'h0,  2'd3, 1'b0, 64'h0, 1'b0, 4'd8},    // R8 any level
        '{1'b0, 1'b0, 1'b1, 32'h0,  2'd0, 1'b0, 64'h0, 1'b0, 4'd8},
        '{1'b0, 1'b0, 1'b1, 32'h0,  2'd2, 1'b1, 64'h0, 1'b1, 4'd9},    // R9 locked
        '{1'b0, 1'b0, 1'b1, 32'h0,  2'd0, 1'b1, 64'h0, 1'b0, 4'd9},    // R9 level 0 ok
        '{1'b0, 1'b1, 1'b0, 32'h10, 2'd0, 1'b0, 64'h12345678_9ABCDEF0, 1'b0, 4'd4}, // R4
        '{1'b1, 1'b0, 1'b0, 32'h10, 2'd0, 1'b0, 64'h0, 1'b0, 4'd4},    // R4 reads load
        '{1'b1, 1'b1, 1'b0, 32'h10, 2'd0, 1'b0, 64'hA5A5A5A5_5A5A5A5A, 1'b0, 4'd11}, // R11
        '{1'b1, 1'b0, 1'b0, 32'h10, 2'd0, 1'b0, 64'h0, 1'b0, 4'd11},
        '{1'b1, 1'b0, 1'b1, 32'h10, 2'd0, 1'b1, 64'h0, 1'b0, 4'd11}    // R11 rd over rdts
    };

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_rd = 1'b0; req_wr = 1'b0; req_rdts = 1'b0;
        req_idx = '0; req_cpl = '0; req_tsd = 1'b0;
        req_wdata_hi = '0; req_wdata_lo = '0;
    endtask

    // Issue one request at a falling edge and check the response one cycle later.
    task automatic request(input vec_t v);
        logic        is_read;
        logic [63:0] exp_data;
        req_rd = v.rd; req_wr = v.wr; req_rdts = v.rdts; req_idx = v.idx;
        req_cpl = v.cpl; req_tsd = v.tsd;
        req_wdata_hi = v.wval[63:32]; req_wdata_lo = v.wval[31:0];
        is_read  = !v.wr && (v.rd || v.rdts);
        exp_data = (is_read && !v.exp_fault) ? model : 64'h0;
        @(negedge clk);
        model = (v.wr && !v.exp_fault) ? v.wval : model + 64'd1;
        idle_inputs();
        check(rsp_valid == 1'b1, int'(v.rq), "valid", 64'(rsp_valid), 64'h1);
        check(rsp_fault == v.exp_fault, int'(v.rq), "fault", 64'(rsp_fault), 64'(v.exp_fault));
        check({rsp_rdata_hi, rsp_rdata_lo} == exp_data, int'(v.rq), "data",
              {rsp_rdata_hi, rsp_rdata_lo}, exp_data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model = model + 64'd1;
        end
    endtask

    function automatic vec_t rd_vec(input int rq);
        vec_t v = '0;
        v.rd = 1'b1; v.idx = 32'h10; v.rq = 4'(rq);
        return v;
    endfunction

    function automatic vec_t wr_vec(input logic [63:0] val, input int rq);
        vec_t v = '0;
        v.wr = 1'b1; v.idx = 32'h10; v.wval = val; v.rq = 4'(rq);
        return v;
    endfunction

    initial begin
        logic [63:0] first;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        check(!rsp_valid && !rsp_fault && rsp_rdata_hi == 0 && rsp_rdata_lo == 0, 1,
              "reset outputs", {rsp_rdata_hi, rsp_rdata_lo}, 64'h0);
        rst_n = 1'b1;
        model = '0;
        // R1: first read after release returns zero
        request(rd_vec(1));

        for (int i = 0; i < NVEC; i++) request(VEC[i]);

        // R2: gap between two reads equals the clock count
        request(rd_vec(2));
        first = model - 64'd1;
        idle(5);
        request(rd_vec(2));
        check({rsp_rdata_hi, rsp_rdata_lo} - first == 64'd6, 2, "increment gap",
              {rsp_rdata_hi, rsp_rdata_lo} - first, 64'd6);

        // R3: wrap from all ones to zero, no fault
        request(wr_vec('1, 3));
        request(rd_vec(3));
        request(rd_vec(3));
        check({rsp_rdata_hi, rsp_rdata_lo} == 64'h0, 3, "wrap value",
              {rsp_rdata_hi, rsp_rdata_lo}, 64'h0);

        // R5: half placement with distinct words
        request(wr_vec(64'hCAFEF00D_01234567, 5));
        request(rd_vec(5));

        // R10: fault is one cycle wide and is not repeated when idle
        begin
            vec_t b = rd_vec(10);
            b.cpl = 2'd1; b.exp_fault = 1'b1;
            request(b);
        end
        idle(1);
        check(!rsp_valid && !rsp_fault, 10, "pulse width", 64'({rsp_valid, rsp_fault}), 64'h0);

        // R1: reset mid-run clears the count
        request(wr_vec(64'h0000_0001_0000_0000, 1));
        rst_n = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !rsp_fault, 1, "reset mid-run", 64'({rsp_valid, rsp_fault}), 64'h0);
        rst_n = 1'b1;
        model = '0;
        request(rd_vec(1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule